// File: doc/BRIEF.md
# PCI Bus Transaction Monitor

This block sits beside a 32-bit PCI bus and only listens. On each rising clock edge it samples the shared address/data lines, the command/byte-enable lines and the FRAME#, IRDY# and TRDY# controls. From these samples it works out which clocks carry an address and a command, and which carry data and byte lanes. It then turns the bus activity into a stream of events that downstream logic can use without knowing the bus protocol.

A transaction is announced with a one-cycle start pulse. The pulse comes with the captured address, a decoded command kind and a flag for the dual-address command. Each completed handshake produces a transfer strobe with the data word and active-high byte lanes. A one-cycle end pulse closes the transaction and reports how many data phases it held. A command from the reserved set raises an error flag that stays set until reset. Every output is registered, so each event is visible one clock after the bus clock that caused it.

Top module: `pci_txn_monitor`

## Requirements
- R1: While the synchronous active-low reset is applied, and on the first clock after it, `txn_start`, `txn_end`, `xfer_valid` and `cmd_err` are all 0 and the monitor is idle, even if FRAME# is low during reset.
- R2: When the monitor is idle and FRAME# is sampled low, `txn_start` is 1 for exactly one cycle on the next clock, and `txn_addr` then holds the AD value sampled at that address phase.
- R3: `txn_kind` reports the command sampled at the address phase as follows: 0 interrupt acknowledge (0000), 1 special cycle (0001), 2 I/O read (0010), 3 I/O write (0011), 4 memory read (0110), 5 memory write (0111), 6 configuration read (1010), 7 configuration write (1011), 8 memory read multiple (1100), 9 dual address (1101), 10 memory read line (1110), 11 memory write and invalidate (1111).
- R4: The command codes 0100, 0101, 1000 and 1001 give `txn_kind` = 15. They set `cmd_err`, which stays 1 until reset, and the transaction is still tracked to its end.
- R5: `txn_dual` is 1 with `txn_start` exactly when the command code is 1101.
- R6: A data-phase clock with IRDY# and TRDY# both low makes `xfer_valid` 1 on the next clock. `xfer_data` then holds the AD value and `xfer_be` holds the inverted C/BE# value, with bit 0 for the least significant byte.
- R7: A data-phase clock with IRDY# or TRDY# high (a wait state) gives `xfer_valid` = 0 on the next clock and does not change the data-phase count.
- R8: A transfer sampled with FRAME# high is the last one. `txn_end` is 1 on the next clock, together with that strobe, and `txn_beats` equals the number of transfers in the transaction. The monitor can accept a new address phase on the very next clock.
- R9: A data-phase clock with FRAME# and IRDY# both high (an aborted transaction) gives `txn_end` on the next clock, with `txn_beats` equal to the transfers completed so far, which may be 0.
- R10: The data-phase count saturates at 2^BEAT_W-1 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ad | input | DATA_W | Shared address/data lines |
| bus_cbe_n | input | DATA_W/8 | Command (address phase) or active-low byte enables (data phase) |
| frame_n | input | 1 | FRAME#, active low |
| irdy_n | input | 1 | IRDY#, initiator ready, active low |
| trdy_n | input | 1 | TRDY#, target ready, active low |
| txn_start | output | 1 | One-cycle pulse at the start of a transaction |
| txn_addr | output | DATA_W | Address captured in the address phase |
| txn_kind | output | 4 | Decoded command kind |
| txn_dual | output | 1 | Dual-address command seen |
| xfer_valid | output | 1 | Data transfer strobe |
| xfer_data | output | DATA_W | Transferred data word |
| xfer_be | output | DATA_W/8 | Active-high byte lanes of the transfer |
| txn_end | output | 1 | One-cycle pulse when a transaction ends |
| txn_beats | output | BEAT_W | Number of data phases in the ended transaction |
| cmd_err | output | 1 | Sticky flag for a reserved command |

## Verification
The bench builds the monitor with DATA_W = 32 and BEAT_W = 3. The narrow count lets a ten-transfer burst run well past the saturation value of 7, which would need tens of thousands of data phases at the default width. The 32-bit data path still exercises all four byte lanes and the full command set. Random bursts mix wait states on either handshake side with back-to-back transactions that have no idle clock between them, and directed cases cover every command code and an aborted transaction with zero transfers.

// File: rtl/pci_mon_pkg.sv
package pci_mon_pkg;

  localparam int CMD_W = 4;

  typedef enum logic [CMD_W-1:0] {
    K_INT_ACK   = 4'd0,
    K_SPECIAL   = 4'd1,
    K_IO_RD     = 4'd2,
    K_IO_WR     = 4'd3,
    K_MEM_RD    = 4'd4,
    K_MEM_WR    = 4'd5,
    K_CFG_RD    = 4'd6,
    K_CFG_WR    = 4'd7,
    K_MEM_RD_M  = 4'd8,
    K_DUAL_ADDR = 4'd9,
    K_MEM_RD_L  = 4'd10,
    K_MEM_WR_I  = 4'd11,
    K_RESERVED  = 4'd15
  } cmd_kind_e;

  // Maps the raw active-low command nibble to a kind.
  function automatic cmd_kind_e decode_cmd(input logic [CMD_W-1:0] code);
    case (code)
      4'b0000: decode_cmd = K_INT_ACK;
      4'b0001: decode_cmd = K_SPECIAL;
      4'b0010: decode_cmd = K_IO_RD;
      4'b0011: decode_cmd = K_IO_WR;
      4'b0110: decode_cmd = K_MEM_RD;
      4'b0111: decode_cmd = K_MEM_WR;
      4'b1010: decode_cmd = K_CFG_RD;
      4'b1011: decode_cmd = K_CFG_WR;
      4'b1100: decode_cmd = K_MEM_RD_M;
      4'b1101: decode_cmd = K_DUAL_ADDR;
      4'b1110: decode_cmd = K_MEM_RD_L;
      4'b1111: decode_cmd = K_MEM_WR_I;
      default: decode_cmd = K_RESERVED;
    endcase
  endfunction

  function automatic logic cmd_is_reserved(input logic [CMD_W-1:0] code);
    return decode_cmd(code) == K_RESERVED;
  endfunction

  function automatic logic cmd_is_dual(input logic [CMD_W-1:0] code);
    return decode_cmd(code) == K_DUAL_ADDR;
  endfunction

endpackage

// File: rtl/pci_mon_phase.sv
module pci_mon_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic irdy_n,
  input  logic trdy_n,
  output logic start_evt,
  output logic xfer_evt,
  output logic last_evt,
  output logic abort_evt,
  output logic in_data
);

  typedef enum logic {ST_IDLE = 1'b0, ST_DATA = 1'b1} phase_e;
  phase_e state_q;

  // Events seen on the current bus clock.
  assign start_evt = (state_q == ST_IDLE) && !frame_n;
  assign xfer_evt  = (state_q == ST_DATA) && !irdy_n && !trdy_n;
  assign last_evt  = xfer_evt && frame_n;
  assign abort_evt = (state_q == ST_DATA) && frame_n && irdy_n;
  assign in_data   = (state_q == ST_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (start_evt) begin
      state_q <= ST_DATA;
    end else if (last_evt || abort_evt) begin
      state_q <= ST_IDLE;
    end
  end

  // R2: an address phase always opens a data-phase window
  assert_start_enters_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> in_data);

  // R8: after the final transfer the tracker is ready for a new address phase
  assert_last_returns_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |=> !in_data);

endmodule

// File: rtl/pci_mon_beats.sv
module pci_mon_beats #(
  parameter int BEAT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              inc,
  output logic [BEAT_W-1:0] count_next
);

  localparam logic [BEAT_W-1:0] BEAT_MAX = {BEAT_W{1'b1}};

  logic [BEAT_W-1:0] count_q;

  function automatic logic [BEAT_W-1:0] sat_inc(input logic [BEAT_W-1:0] v);
    return (v == BEAT_MAX) ? v : v + 1'b1;
  endfunction

  always_comb begin
    if (clear)    count_next = '0;
    else if (inc) count_next = sat_inc(count_q);
    else          count_next = count_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_next;
  end

  // R10: a full counter stays full until cleared
  assert_beats_saturate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == BEAT_MAX) && !clear |=> count_q == BEAT_MAX);

  // R7: without an increment or clear the count holds
  assert_wait_holds_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !inc && !clear |=> $stable(count_q));

endmodule

// File: rtl/pci_txn_monitor.sv
module pci_txn_monitor
  import pci_mon_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BEAT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DATA_W-1:0]     bus_ad,
  input  logic [DATA_W/8-1:0]   bus_cbe_n,
  input  logic                  frame_n,
  input  logic                  irdy_n,
  input  logic                  trdy_n,
  output logic                  txn_start,
  output logic [DATA_W-1:0]     txn_addr,
  output logic [3:0]            txn_kind,
  output logic                  txn_dual,
  output logic                  xfer_valid,
  output logic [DATA_W-1:0]     xfer_data,
  output logic [DATA_W/8-1:0]   xfer_be,
  output logic                  txn_end,
  output logic [BEAT_W-1:0]     txn_beats,
  output logic                  cmd_err
);

  localparam int BE_W = DATA_W / 8;

  logic              start_evt, xfer_evt, last_evt, abort_evt, in_data;
  logic              end_evt;
  logic [BEAT_W-1:0] beats_next;
  logic [CMD_W-1:0]  cmd_code;

  function automatic logic [BE_W-1:0] lanes_of(input logic [BE_W-1:0] be_n);
    return ~be_n;
  endfunction

  assign cmd_code = bus_cbe_n[CMD_W-1:0];
  assign end_evt  = last_evt || abort_evt;

  pci_mon_phase u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .trdy_n    (trdy_n),
    .start_evt (start_evt),
    .xfer_evt  (xfer_evt),
    .last_evt  (last_evt),
    .abort_evt (abort_evt),
    .in_data   (in_data)
  );

  pci_mon_beats #(.BEAT_W(BEAT_W)) u_beats (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start_evt),
    .inc        (xfer_evt),
    .count_next (beats_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txn_start  <= 1'b0;
      txn_addr   <= '0;
      txn_kind   <= 4'd0;
      txn_dual   <= 1'b0;
      xfer_valid <= 1'b0;
      xfer_data  <= '0;
      xfer_be    <= '0;
      txn_end    <= 1'b0;
      txn_beats  <= '0;
      cmd_err    <= 1'b0;
    end else begin
      txn_start  <= start_evt;
      xfer_valid <= xfer_evt;
      txn_end    <= end_evt;
      if (start_evt) begin
        txn_addr <= bus_ad;
        txn_kind <= decode_cmd(cmd_code);
        txn_dual <= cmd_is_dual(cmd_code);
        if (cmd_is_reserved(cmd_code)) cmd_err <= 1'b1;
      end
      if (xfer_evt) begin
        xfer_data <= bus_ad;
        xfer_be   <= lanes_of(bus_cbe_n);
      end
      if (end_evt) txn_beats <= beats_next;
    end
  end

  // R6: a strobe only follows a clock with both ready signals low
  assert_xfer_needs_handshake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> $past(!irdy_n && !trdy_n));

  // R7: a wait state never yields a strobe
  assert_wait_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irdy_n || trdy_n) |=> !xfer_valid);

  // R8: an end pulse only follows a clock with FRAME# released
  assert_end_after_frame_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    txn_end |-> $past(frame_n));

  // R4: the reserved-command flag is sticky
  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err);

  // R2: start pulse lasts a single cycle
  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start |=> !txn_start);

  // R5: the dual flag only accompanies the dual-address kind
  assert_dual_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    txn_start && txn_dual |-> txn_kind == 4'd9);

endmodule

// File: tb/pci_txn_monitor_bench.sv
module pci_txn_monitor_bench;

  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int BEAT_W = 3;
  localparam int BMAX   = (1 << BEAT_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DATA_W-1:0] bus_ad = '0;
  logic [BE_W-1:0]   bus_cbe_n = '1;
  logic              frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
  logic              txn_start, txn_dual, xfer_valid, txn_end, cmd_err;
  logic [DATA_W-1:0] txn_addr, xfer_data;
  logic [3:0]        txn_kind;
  logic [BE_W-1:0]   xfer_be;
  logic [BEAT_W-1:0] txn_beats;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  exp_err  = 1'b0;
  bit  done     = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pci_txn_monitor #(.DATA_W(DATA_W), .BEAT_W(BEAT_W)) u_pci_txn_monitor (
    .clk(clk), .rst_n(rst_n), .bus_ad(bus_ad), .bus_cbe_n(bus_cbe_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .txn_start(txn_start), .txn_addr(txn_addr), .txn_kind(txn_kind),
    .txn_dual(txn_dual), .xfer_valid(xfer_valid), .xfer_data(xfer_data),
    .xfer_be(xfer_be), .txn_end(txn_end), .txn_beats(txn_beats),
    .cmd_err(cmd_err)
  );

  // Reserved codes are 4,5,8,9; valid codes are numbered upward from 0.
  function automatic bit is_rsvd(input logic [3:0] c);
    return (c == 4'd4) || (c == 4'd5) || (c == 4'd8) || (c == 4'd9);
  endfunction

  function automatic logic [3:0] exp_kind(input logic [3:0] c);
    int k = 0;
    if (is_rsvd(c)) return 4'd15;
    for (int v = 0; v < 16; v++)
      if (v < int'(c) && !is_rsvd(v[3:0])) k++;
    return k[3:0];
  endfunction

  function automatic int sat_beats(input int n);
    return (n > BMAX) ? BMAX : n;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic f, input logic i, input logic t,
                       input logic [DATA_W-1:0] ad, input logic [BE_W-1:0] cbe);
    frame_n = f; irdy_n = i; trdy_n = t; bus_ad = ad; bus_cbe_n = cbe;
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // nb = 0 gives an aborted transaction with no transfers.
  task automatic run_txn(input logic [31:0] addr, input logic [3:0] cmd,
                         input int nb, input bit no_idle);
    if (!no_idle) begin
      drive(1, 1, 1, $urandom, 4'hF);
      step();
      chk(txn_start == 0 && xfer_valid == 0, "R2", "idle no start", {txn_start, xfer_valid}, 0);
    end
    drive(0, 1, 1, addr, cmd);
    step();
    if (is_rsvd(cmd)) exp_err = 1'b1;
    chk(txn_start == 1, "R2", "start pulse", txn_start, 1);
    chk(txn_addr == addr, "R2", "address", txn_addr, addr);
    chk(txn_kind == exp_kind(cmd), is_rsvd(cmd) ? "R4" : "R3", "kind", txn_kind, exp_kind(cmd));
    chk(txn_dual == (cmd == 4'hD), "R5", "dual flag", txn_dual, (cmd == 4'hD));
    chk(cmd_err == exp_err, "R4", "error flag", cmd_err, exp_err);
    if (nb == 0) begin
      drive(1, 1, 1, $urandom, 4'hF);
      step();
      chk(txn_end == 1 && txn_beats == 0, "R9", "abort end/beats", {txn_end, txn_beats}, {1'b1, 3'b0});
      chk(xfer_valid == 0, "R9", "abort no strobe", xfer_valid, 0);
      return;
    end
    for (int b = 0; b < nb; b++) begin
      int w = $urandom_range(0, 2);
      for (int k = 0; k < w; k++) begin
        logic ir = 1'($urandom_range(0, 1));
        logic tr = ir ? 1'($urandom_range(0, 1)) : 1'b1;
        drive(0, ir, tr, $urandom, 4'($urandom));
        step();
        chk(xfer_valid == 0 && txn_end == 0, "R7", "wait state strobe", {xfer_valid, txn_end}, 0);
      end
      begin
        logic [31:0] d  = $urandom;
        logic [3:0]  bn = 4'($urandom);
        bit          last = (b == nb - 1);
        drive(last, 0, 0, d, bn);
        step();
        chk(xfer_valid == 1 && xfer_data == d, "R6", "strobe data", xfer_data, d);
        chk(xfer_be == ~bn, "R6", "byte lanes", xfer_be, ~bn);
        chk(txn_end == last, "R8", "end pulse", txn_end, last);
        if (last)
          chk(int'(txn_beats) == sat_beats(nb), nb > BMAX ? "R10" : "R8", "beat count",
              txn_beats, sat_beats(nb));
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin : stim
    void'($urandom(32'd20051130));
    // R1: reset dominates a low FRAME#
    drive(0, 1, 1, 32'h1234_5678, 4'h6);
    step(); step();
    chk(txn_start == 0 && txn_end == 0 && xfer_valid == 0 && cmd_err == 0,
        "R1", "reset outputs", {txn_start, txn_end, xfer_valid, cmd_err}, 0);
    drive(1, 1, 1, '0, 4'hF);
    rst_n = 1'b1;
    step();
    chk(txn_start == 0 && cmd_err == 0, "R1", "after reset", {txn_start, cmd_err}, 0);

    // R3/R4/R5: every command code once
    for (int c = 0; c < 16; c++) run_txn($urandom, c[3:0], 1, 1'b0);

    // R1: reset clears the sticky error
    drive(1, 1, 1, '0, 4'hF);
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    exp_err = 1'b0;
    step();
    chk(cmd_err == 0, "R1", "error cleared by reset", cmd_err, 0);

    // R9: abort with zero transfers, then R8 back-to-back
    run_txn(32'hDEAD_0000, 4'h7, 0, 1'b0);
    run_txn(32'h0000_1000, 4'h6, 2, 1'b0);
    run_txn(32'h0000_2000, 4'h7, 3, 1'b1);
    // R10: burst beyond the saturation value
    run_txn(32'h0000_3000, 4'hF, 10, 1'b0);

    for (int n = 0; n < 40; n++)
      run_txn($urandom, 4'($urandom), $urandom_range(1, 5), 1'($urandom_range(0, 1)));

    drive(1, 1, 1, '0, 4'hF);
    step();
    done = 1'b1;
    report();
  end

endmodule